// File: doc/BRIEF.md
# Auto-reloading decrementer timer

This block is a down-counter clocked by the time-base tick enable. Each tick takes one off the count. When the count steps from one to zero the block records an expiry in a sticky status flag. Software clears that flag by writing a one to its bit position. If auto-reload is selected when the count expires, the counter restarts from a separate reload register instead of resting at zero. That gives a periodic interrupt without a software rewrite each period.

Software writes the counter and the reload register through two write ports. The auto-reload select and the interrupt enable come in as levels from a control register outside the block. The interrupt output is the flag gated by the enable. The block does not generate the tick.

Top module: `dectmr_top`

## Requirements
- R1: After reset the count is 0, the reload register is 0, the status flag is clear and the interrupt output is low.
- R2: On each cycle with `tick_en` high and a nonzero count, the count drops by exactly one. Without a tick the count holds.
- R3: A tick that moves the count from 1 to 0 sets the status flag. The flag is visible on the cycle after that edge and stays set until it is cleared.
- R4: If `reload_on` is high when the count expires, the count takes the reload register's value instead of 0. It then keeps counting down from that value.
- R5: `irq_o` is high exactly when the status flag is set and `irq_en` is high, with no register delay from `irq_en`.
- R6: A status write with bit 27 of `sts_wr_data` at 1 clears the flag. With bit 27 at 0 the flag is unchanged, and all other bits of that word are ignored.
- R7: Without auto-reload, a count of 0 holds under further ticks and causes no further expiry, so a cleared flag stays clear.
- R8: A counter write in the same cycle as a tick wins. The count takes the written value, and no expiry is recorded even if the count was 1.
- R9: If an expiry and a clearing status write fall in the same cycle, the flag ends up set.
- R10: A reload-register write does not change the count. An expiry in the same cycle as a reload write loads the old reload value, and the new value applies from the next expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base tick; one decrement per high cycle |
| cnt_wr_en | input | 1 | Counter write strobe |
| cnt_wr_data | input | 32 | Value written to the counter |
| rld_wr_en | input | 1 | Reload register write strobe |
| rld_wr_data | input | 32 | Value written to the reload register |
| reload_on | input | 1 | Auto-reload select from the control register |
| irq_en | input | 1 | Interrupt enable from the control register |
| sts_wr_en | input | 1 | Status write strobe (write-one-to-clear) |
| sts_wr_data | input | 32 | Status write word; bit 27 clears the flag |
| count_o | output | 32 | Current count |
| flag_o | output | 1 | Sticky expiry status flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the collisions on the expiry edge: a count of one meeting a tick in the same cycle as a counter write, a clearing status write, or a reload-register write. Each has its own priority rule. The stimulus gets there by writing the count to one, so the next tick is known to be the expiring one, and then raising the tick together with the colliding strobe on that single cycle. A long random phase then mixes small count values, frequent ticks and random strobes, so these collisions also occur unplanned. A per-cycle reference model catches them.

// File: rtl/dectmr_pkg.sv
package dectmr_pkg;
  localparam int unsigned DEF_CNT_W   = 32;
  localparam int unsigned DEF_STS_W   = 32;
  localparam int unsigned DEF_FLAG_BIT = 27;

  // Operation selected for the counter in the current cycle
  typedef enum logic [1:0] {
    CNT_HOLD   = 2'd0,
    CNT_LOAD   = 2'd1,
    CNT_DEC    = 2'd2,
    CNT_EXPIRE = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/dectmr_reload.sv
module dectmr_reload #(
  parameter int unsigned W = dectmr_pkg::DEF_CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] reload_q
);
  logic [W-1:0] reload_d;
  logic         reload_ce;

  always_comb begin
    reload_ce = wr_en;
    reload_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (reload_ce) begin
      reload_q <= reload_d;
    end
  end
endmodule

// File: rtl/dectmr_counter.sv
module dectmr_counter
  import dectmr_pkg::*;
#(
  parameter int unsigned W = DEF_CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         reload_on,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] count_q,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  cnt_op_e      op;
  logic [W-1:0] count_d;
  logic         count_ce;

  // Software write beats the tick; a zero count ignores ticks
  always_comb begin
    op = CNT_HOLD;
    if (wr_en) begin
      op = CNT_LOAD;
    end else if (tick_en && (count_q != '0)) begin
      op = (count_q == ONE) ? CNT_EXPIRE : CNT_DEC;
    end
  end

  always_comb begin
    unique case (op)
      CNT_LOAD:   count_d = wr_data;
      CNT_DEC:    count_d = count_q - ONE;
      CNT_EXPIRE: count_d = reload_on ? reload_val : '0;
      default:    count_d = count_q;
    endcase
    count_ce = (op != CNT_HOLD);
    expire_o = (op == CNT_EXPIRE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_ce) begin
      count_q <= count_d;
    end
  end
endmodule

// File: rtl/dectmr_status.sv
module dectmr_status #(
  parameter int unsigned SW       = dectmr_pkg::DEF_STS_W,
  parameter int unsigned FLAG_BIT = dectmr_pkg::DEF_FLAG_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          expire,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_data,
  input  logic          irq_en,
  output logic          flag_q,
  output logic          irq_o
);
  localparam logic [SW-1:0] FLAG_MASK = {{(SW-1){1'b0}}, 1'b1} << FLAG_BIT;

  logic flag_set;
  logic flag_clr;
  logic flag_d;
  logic flag_ce;
  logic unused_bits;

  // Only the flag position of a status write matters
  assign unused_bits = ^(wr_data & ~FLAG_MASK);

  always_comb begin
    flag_set = expire;
    flag_clr = wr_en && wr_data[FLAG_BIT];
    // A hardware expiry outranks a software clear in the same cycle
    flag_d   = flag_set || (flag_q && !flag_clr);
    flag_ce  = flag_set || flag_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_ce) begin
      flag_q <= flag_d;
    end
  end

  assign irq_o = flag_q && irq_en;
endmodule

// File: rtl/dectmr_top.sv
module dectmr_top
  import dectmr_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned STS_W    = DEF_STS_W,
  parameter int unsigned FLAG_BIT = DEF_FLAG_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             rld_wr_en,
  input  logic [CNT_W-1:0] rld_wr_data,
  input  logic             reload_on,
  input  logic             irq_en,
  input  logic             sts_wr_en,
  input  logic [STS_W-1:0] sts_wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] reload_q;
  logic             expire;

  dectmr_reload #(.W(CNT_W)) u_reload (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (rld_wr_en),
    .wr_data  (rld_wr_data),
    .reload_q (reload_q)
  );

  dectmr_counter #(.W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .wr_en      (cnt_wr_en),
    .wr_data    (cnt_wr_data),
    .reload_on  (reload_on),
    .reload_val (reload_q),
    .count_q    (count_o),
    .expire_o   (expire)
  );

  dectmr_status #(.SW(STS_W), .FLAG_BIT(FLAG_BIT)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .wr_en   (sts_wr_en),
    .wr_data (sts_wr_data),
    .irq_en  (irq_en),
    .flag_q  (flag_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/dectmr_checker.sv
module dectmr_checker #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned STS_W    = 32,
  parameter int unsigned FLAG_BIT = 27
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             cnt_wr_en,
  input logic [CNT_W-1:0] cnt_wr_data,
  input logic             reload_on,
  input logic             irq_en,
  input logic             sts_wr_en,
  input logic [STS_W-1:0] sts_wr_data,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] count_o,
  input logic             flag_o,
  input logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic hits_one;
  assign hits_one = tick_en && !cnt_wr_en && (count_o == ONE);

  // R3: the expiring tick leaves the flag set
  a_r3_expiry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hits_one |=> flag_o);

  // R3: the flag only rises after an expiring tick
  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(hits_one));

  // R4: auto-reload loads the reload register on expiry
  a_r4_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    (hits_one && reload_on) |=> (count_o == $past(reload_q)));

  // R5: no interrupt without enable or without flag
  a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_o);
  a_r5_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_o |-> !irq_o);

  // R6: clearing write without a coinciding expiry drops the flag
  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr_en && sts_wr_data[FLAG_BIT] && !hits_one) |=> !flag_o);

  // R7: zero holds under ticks when not written
  a_r7_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((count_o == '0) && !cnt_wr_en) |=> (count_o == '0));

  // R8: a counter write always lands
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> (count_o == $past(cnt_wr_data)));

  // R9: expiry beats a same-cycle clear
  a_r9_set_over_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hits_one && sts_wr_en && sts_wr_data[FLAG_BIT]) |=> flag_o);
endmodule

bind dectmr_top dectmr_checker #(
  .CNT_W(CNT_W), .STS_W(STS_W), .FLAG_BIT(FLAG_BIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .cnt_wr_en   (cnt_wr_en),
  .cnt_wr_data (cnt_wr_data),
  .reload_on   (reload_on),
  .irq_en      (irq_en),
  .sts_wr_en   (sts_wr_en),
  .sts_wr_data (sts_wr_data),
  .reload_q    (reload_q),
  .count_o     (count_o),
  .flag_o      (flag_o),
  .irq_o       (irq_o)
);

// File: tb/dectmr_top_tb_top.sv
`timescale 1ns/1ps
module dectmr_top_tb_top;
  localparam int W  = 32;
  localparam int FB = 27;
  localparam logic [31:0] CLR = 32'h1 << FB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_en, cnt_wr_en, rld_wr_en, reload_on, irq_en, sts_wr_en;
  logic [W-1:0]  cnt_wr_data, rld_wr_data;
  logic [31:0]   sts_wr_data;
  logic [W-1:0]  count_o;
  logic          flag_o, irq_o;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  dectmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .rld_wr_en(rld_wr_en), .rld_wr_data(rld_wr_data),
    .reload_on(reload_on), .irq_en(irq_en),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data),
    .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  // Behavioural reference model
  logic [31:0] m_cnt, m_rld;
  bit          m_flag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_rld = 0; m_flag = 0;
    end else begin
      bit          expd;
      logic [31:0] nc;
      expd = tick_en && !cnt_wr_en && (m_cnt == 1);
      if (cnt_wr_en)               nc = cnt_wr_data;
      else if (expd)               nc = reload_on ? m_rld : 0;
      else if (tick_en && m_cnt != 0) nc = m_cnt - 1;
      else                         nc = m_cnt;
      if (expd)                              m_flag = 1;
      else if (sts_wr_en && sts_wr_data[FB]) m_flag = 0;
      if (rld_wr_en) m_rld = rld_wr_data;
      m_cnt = nc;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk(cur_req, "model count", count_o, m_cnt);
      chk(cur_req, "model flag", {31'b0, flag_o}, {31'b0, m_flag});
      chk(cur_req, "model irq", {31'b0, irq_o}, {31'b0, m_flag && irq_en});
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
    tick_en = 0; cnt_wr_en = 0; rld_wr_en = 0; sts_wr_en = 0;
  endtask

  task automatic wr_cnt(logic [31:0] v);
    cnt_wr_en = 1; cnt_wr_data = v; step();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick_en = 1; step(); end
  endtask

  task automatic clr_flag();
    sts_wr_en = 1; sts_wr_data = CLR; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; tick_en = 0; cnt_wr_en = 0; rld_wr_en = 0; sts_wr_en = 0;
    reload_on = 0; irq_en = 0; cnt_wr_data = 0; rld_wr_data = 0; sts_wr_data = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    step();
    // R1 reset state
    chk("R1", "count", count_o, 0);
    chk("R1", "flag", {31'b0, flag_o}, 0);
    chk("R1", "irq", {31'b0, irq_o}, 0);
    reload_on = 1; wr_cnt(1); ticks(1);
    chk("R1", "reload reg default", count_o, 0);
    reload_on = 0; clr_flag();

    // R2 decrement only on ticks
    cur_req = "R2";
    wr_cnt(5); step(); step(); step();
    chk("R2", "hold without tick", count_o, 5);
    ticks(1); chk("R2", "one tick", count_o, 4);
    ticks(3); chk("R2", "at one", count_o, 1);
    chk("R2", "no early flag", {31'b0, flag_o}, 0);

    // R3 expiry
    cur_req = "R3";
    ticks(1);
    chk("R3", "count at zero", count_o, 0);
    chk("R3", "flag set", {31'b0, flag_o}, 1);

    // R5 interrupt gating
    cur_req = "R5";
    irq_en = 0; #1 chk("R5", "irq masked", {31'b0, irq_o}, 0);
    irq_en = 1; #1 chk("R5", "irq on", {31'b0, irq_o}, 1);

    // R6 write-one-to-clear
    cur_req = "R6";
    sts_wr_en = 1; sts_wr_data = ~CLR; step();
    chk("R6", "zero at bit 27 keeps flag", {31'b0, flag_o}, 1);
    clr_flag();
    chk("R6", "flag cleared", {31'b0, flag_o}, 0);
    chk("R6", "irq dropped", {31'b0, irq_o}, 0);

    // R7 stop at zero
    cur_req = "R7";
    ticks(4);
    chk("R7", "count stays zero", count_o, 0);
    chk("R7", "no re-expiry", {31'b0, flag_o}, 0);

    // R10 reload write leaves count alone
    cur_req = "R10";
    wr_cnt(9); rld_wr_en = 1; rld_wr_data = 3; step();
    chk("R10", "count untouched", count_o, 9);

    // R4 auto-reload
    cur_req = "R4";
    reload_on = 1; wr_cnt(2); ticks(2);
    chk("R4", "reloaded", count_o, 3);
    chk("R4", "flag on reload", {31'b0, flag_o}, 1);
    clr_flag(); ticks(3);
    chk("R4", "second period", count_o, 3);
    chk("R4", "second flag", {31'b0, flag_o}, 1);

    // R10 same-cycle reload write and expiry
    cur_req = "R10";
    clr_flag(); wr_cnt(1);
    tick_en = 1; rld_wr_en = 1; rld_wr_data = 20; step();
    chk("R10", "old reload used", count_o, 3);
    ticks(3);
    chk("R10", "new reload next", count_o, 20);

    // R8 write priority
    cur_req = "R8";
    reload_on = 0; clr_flag(); wr_cnt(1);
    tick_en = 1; cnt_wr_en = 1; cnt_wr_data = 50; step();
    chk("R8", "write wins at one", count_o, 50);
    chk("R8", "no expiry", {31'b0, flag_o}, 0);
    tick_en = 1; cnt_wr_en = 1; cnt_wr_data = 10; step();
    chk("R8", "write wins mid", count_o, 10);

    // R9 set beats clear
    cur_req = "R9";
    wr_cnt(1);
    tick_en = 1; sts_wr_en = 1; sts_wr_data = CLR; step();
    chk("R9", "flag kept", {31'b0, flag_o}, 1);

    // Random mix, compared per cycle against the model
    cur_req = "R3";
    for (int i = 0; i < 3000; i++) begin
      tick_en     = ($urandom_range(0, 1) == 1);
      cnt_wr_en   = ($urandom_range(0, 9) == 0);
      cnt_wr_data = $urandom_range(0, 6);
      rld_wr_en   = ($urandom_range(0, 15) == 0);
      rld_wr_data = $urandom_range(0, 5);
      sts_wr_en   = ($urandom_range(0, 7) == 0);
      sts_wr_data = $urandom;
      if ($urandom_range(0, 31) == 0) reload_on = ~reload_on;
      if ($urandom_range(0, 31) == 0) irq_en = ~irq_en;
      step();
    end

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule